// File: doc/BRIEF.md
# Prefix-Matching Partial Translation Cache

This block holds a handful of partial address translations so that a hardware page walker can skip the upper levels of a four-level radix page table. Each entry is tagged by one, two or three of the virtual-address table indices, counted from the top. The indices it does not cover are ignored when matching. The entry holds the physical page number of the table one level below the last index it covers. Entries of all three prefix lengths share a single fully associative array and are searched in parallel.

The walker presents the four 9-bit indices of a missing address together with the root table base. One cycle later the block answers with the level at which the walk must resume and the base of the table to read there. When several entries match, the longest prefix wins. When nothing matches, the walk starts from the root. After a walk completes, the walker writes back the three intermediate table bases in one fill. Each of the three prefixes is stored only if the array does not already hold it, and new entries go to slots picked by a round-robin pointer. A flush input empties the whole array in one cycle.

Top module: `utc_top`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, `rsp_level` is 4 and `rsp_ppn` is 0, and any lookup misses.
- R2: A lookup sampled with `lk_req` high at a clock edge produces `rsp_valid` high in the following cycle only. `rsp_valid` is low in any cycle that follows an edge without `lk_req`.
- R3: A lookup that matches no valid entry returns `rsp_level` = 4 (full walk) and `rsp_ppn` equal to the `lk_root` sampled with the request.
- R4: An entry with prefix length n (1 to 3) matches when the top n indices of `lk_vidx` equal its stored ones. The lower indices and the level-1 index are ignored. A matching entry returns its stored base with `rsp_level` = 4 − n.
- R5: When entries of several prefix lengths match the same lookup, the response comes from the longest one.
- R6: A fill with key (a,b,c) stores prefix (a) with base `fill_base_l3`, prefix (a,b) with `fill_base_l2` and prefix (a,b,c) with `fill_base_l1`.
- R7: A prefix that is already held with the same length is not stored again by a fill. It keeps its old base and uses no slot, so the array never holds two matching entries of one length.
- R8: New entries of one fill take consecutive slots starting at the round-robin pointer, in the order 1-, 2-, then 3-index prefix. The pointer wraps after the last slot, and the slot's previous contents are replaced.
- R9: `flush_all` invalidates every entry and returns the pointer to slot 0. A fill in the same cycle is dropped.
- R10: A lookup and a fill in the same cycle: the lookup sees the contents from before the fill. A lookup and a flush in the same cycle: the lookup sees the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| lk_req | input | 1 | Lookup request |
| lk_vidx | input | 4*IDX_W | Table indices, top level in the most significant field, level-1 index in the least |
| lk_root | input | PPN_W | Root table base returned on a miss |
| fill_en | input | 1 | Store the prefixes of a completed walk |
| fill_key | input | 3*IDX_W | Top three indices of the walked address, top level most significant |
| fill_base_l3 | input | PPN_W | Base of the level-3 table (for the 1-index prefix) |
| fill_base_l2 | input | PPN_W | Base of the level-2 table (for the 2-index prefix) |
| fill_base_l1 | input | PPN_W | Base of the level-1 table (for the 3-index prefix) |
| rsp_valid | output | 1 | Response valid |
| rsp_level | output | 3 | Resume level, 4 = full walk, 1 = only the leaf read remains |
| rsp_ppn | output | PPN_W | Base of the table to read at the resume level |

## Verification
A lookup and a fill for the same address can arrive in the same cycle, since a walker commonly issues the next lookup while the previous walk is being written back. The bench provokes this on purpose: a fill completes a prefix that was held only two levels deep, and a lookup of that address is issued in the same cycle. The response must still report resume level 2, and only a later lookup may report level 1. The same collision also occurs often under the random mix, where keys come from a small pool. Each of those responses is judged against a bench model that applies a fill or flush only after it has evaluated the lookup.

// File: rtl/utc_pkg.sv
package utc_pkg;

    // resume level reported to the walker
    typedef enum logic [2:0] {
        WALK_L1   = 3'd1,
        WALK_L2   = 3'd2,
        WALK_L3   = 3'd3,
        WALK_FULL = 3'd4
    } walk_lvl_e;

    // number of prefix lengths an entry may cover
    localparam int NUM_PFX = 3;

    // prefix length code 0 never names a valid entry
    localparam logic [1:0] PFX_NONE = 2'd0;

endpackage

// File: rtl/utc_match.sv
module utc_match #(
    parameter int IDX_W   = 9,
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]                   ent_vld,
    input  logic [ENTRIES-1:0][1:0]              ent_plen,
    input  logic [ENTRIES-1:0][3*IDX_W-1:0]      ent_tag,
    input  logic [3*IDX_W-1:0]                   key,
    output logic [ENTRIES-1:0]                   hit
);
    localparam int TAG_W = 3*IDX_W;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [2:0] fld_eq;
        for (genvar f = 0; f < 3; f++) begin : g_fld
            assign fld_eq[f] = ent_tag[e][TAG_W-1-f*IDX_W -: IDX_W] == key[TAG_W-1-f*IDX_W -: IDX_W];
        end
        // fields below the entry's prefix length are don't-care
        assign hit[e] = ent_vld[e]
                      && (ent_plen[e] != utc_pkg::PFX_NONE)
                      && fld_eq[0]
                      && ((ent_plen[e] < 2'd2) || fld_eq[1])
                      && ((ent_plen[e] < 2'd3) || fld_eq[2]);
    end

endmodule

// File: rtl/utc_select.sv
module utc_select #(
    parameter int PPN_W   = 12,
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]               hit,
    input  logic [ENTRIES-1:0][1:0]          ent_plen,
    input  logic [ENTRIES-1:0][PPN_W-1:0]    ent_ppn,
    input  logic [PPN_W-1:0]                 root,
    output logic [2:0]                       lvl,
    output logic [PPN_W-1:0]                 base
);
    logic [1:0]        best_len;
    logic [PPN_W-1:0]  best_ppn;

    always_comb begin
        best_len = utc_pkg::PFX_NONE;
        best_ppn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit[e] && (ent_plen[e] > best_len)) begin
                best_len = ent_plen[e];
                best_ppn = ent_ppn[e];
            end
        end
        if (best_len == utc_pkg::PFX_NONE) begin
            lvl  = utc_pkg::WALK_FULL;
            base = root;
        end else begin
            lvl  = 3'(utc_pkg::WALK_FULL) - {1'b0, best_len};
            base = best_ppn;
        end
    end

endmodule

// File: rtl/utc_alloc.sv
module utc_alloc #(
    parameter int ENTRIES = 8,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]          fill_hit,
    input  logic [ENTRIES-1:0][1:0]     ent_plen,
    input  logic [PTR_W-1:0]            ptr,
    output logic [2:0]                  need,
    output logic [2:0][PTR_W-1:0]       slot,
    output logic [1:0]                  cnt,
    output logic [PTR_W-1:0]            ptr_next
);
    localparam logic [PTR_W:0] DEPTH = (PTR_W+1)'(ENTRIES);

    function automatic logic [PTR_W-1:0] wrap_add(logic [PTR_W-1:0] base, logic [1:0] off);
        logic [PTR_W:0] s;
        s = {1'b0, base} + (PTR_W+1)'(off);
        if (s >= DEPTH) s = s - DEPTH;
        return s[PTR_W-1:0];
    endfunction

    // presence of each prefix length among the entries the fill key matches
    for (genvar k = 0; k < utc_pkg::NUM_PFX; k++) begin : g_need
        logic [ENTRIES-1:0] same_len;
        for (genvar e = 0; e < ENTRIES; e++) begin : g_e
            assign same_len[e] = fill_hit[e] && (ent_plen[e] == 2'(k+1));
        end
        assign need[k] = ~|same_len;
    end

    always_comb begin
        logic [1:0] acc;
        acc = '0;
        for (int k = 0; k < utc_pkg::NUM_PFX; k++) begin
            slot[k] = wrap_add(ptr, acc);
            acc     = acc + {1'b0, need[k]};
        end
        cnt      = acc;
        ptr_next = wrap_add(ptr, acc);
    end

endmodule

// File: rtl/utc_top.sv
module utc_top #(
    parameter int IDX_W   = 9,
    parameter int PPN_W   = 12,
    parameter int ENTRIES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_all,
    input  logic                    lk_req,
    input  logic [4*IDX_W-1:0]      lk_vidx,
    input  logic [PPN_W-1:0]        lk_root,
    input  logic                    fill_en,
    input  logic [3*IDX_W-1:0]      fill_key,
    input  logic [PPN_W-1:0]        fill_base_l3,
    input  logic [PPN_W-1:0]        fill_base_l2,
    input  logic [PPN_W-1:0]        fill_base_l1,
    output logic                    rsp_valid,
    output logic [2:0]              rsp_level,
    output logic [PPN_W-1:0]        rsp_ppn
);
    localparam int TAG_W = 3*IDX_W;
    localparam int PTR_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]               vld;
        logic [ENTRIES-1:0][1:0]          plen;
        logic [ENTRIES-1:0][TAG_W-1:0]    tag;
        logic [ENTRIES-1:0][PPN_W-1:0]    ppn;
        logic [PTR_W-1:0]                 ptr;
        logic                             rsp_v;
        logic [2:0]                       rsp_lvl;
        logic [PPN_W-1:0]                 rsp_ppn;
    } utc_state_t;

    utc_state_t st_q, st_d;

    // views of the state for the sub-blocks and the bound checker
    logic [ENTRIES-1:0]             ent_vld;
    logic [ENTRIES-1:0][1:0]        ent_plen;
    logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
    logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
    logic [PTR_W-1:0]               ptr_q;
    assign ent_vld  = st_q.vld;
    assign ent_plen = st_q.plen;
    assign ent_tag  = st_q.tag;
    assign ent_ppn  = st_q.ppn;
    assign ptr_q    = st_q.ptr;

    logic [ENTRIES-1:0]       lk_hit;
    logic [ENTRIES-1:0]       fill_hit;
    logic [2:0]               sel_lvl;
    logic [PPN_W-1:0]         sel_ppn;
    logic [2:0]               alloc_need;
    logic [2:0][PTR_W-1:0]    alloc_slot;
    logic [1:0]               alloc_cnt;
    logic [PTR_W-1:0]         alloc_ptr_next;
    logic [2:0][PPN_W-1:0]    fill_base;

    // index 0 pairs with the 1-index prefix
    assign fill_base = {fill_base_l1, fill_base_l2, fill_base_l3};

    utc_match #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_lk_match (
        .ent_vld  (ent_vld),
        .ent_plen (ent_plen),
        .ent_tag  (ent_tag),
        .key      (lk_vidx[4*IDX_W-1:IDX_W]),
        .hit      (lk_hit)
    );

    utc_match #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_fill_match (
        .ent_vld  (ent_vld),
        .ent_plen (ent_plen),
        .ent_tag  (ent_tag),
        .key      (fill_key),
        .hit      (fill_hit)
    );

    utc_select #(.PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_select (
        .hit      (lk_hit),
        .ent_plen (ent_plen),
        .ent_ppn  (ent_ppn),
        .root     (lk_root),
        .lvl      (sel_lvl),
        .base     (sel_ppn)
    );

    utc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .fill_hit (fill_hit),
        .ent_plen (ent_plen),
        .ptr      (ptr_q),
        .need     (alloc_need),
        .slot     (alloc_slot),
        .cnt      (alloc_cnt),
        .ptr_next (alloc_ptr_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsp_v   = lk_req;
        if (lk_req) begin
            st_d.rsp_lvl = sel_lvl;
            st_d.rsp_ppn = sel_ppn;
        end
        if (flush_all) begin
            st_d.vld = '0;
            st_d.ptr = '0;
        end else if (fill_en) begin
            for (int k = 0; k < utc_pkg::NUM_PFX; k++) begin
                if (alloc_need[k]) begin
                    st_d.vld[alloc_slot[k]]  = 1'b1;
                    st_d.plen[alloc_slot[k]] = 2'(k+1);
                    st_d.tag[alloc_slot[k]]  = fill_key;
                    st_d.ppn[alloc_slot[k]]  = fill_base[k];
                end
            end
            st_d.ptr = alloc_ptr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rsp_lvl <= utc_pkg::WALK_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_level = st_q.rsp_lvl;
    assign rsp_ppn   = st_q.rsp_ppn;

endmodule

// File: rtl/utc_top_chk.sv
module utc_top_chk #(
    parameter int IDX_W   = 9,
    parameter int PPN_W   = 12,
    parameter int ENTRIES = 8,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush_all,
    input logic                    lk_req,
    input logic [PPN_W-1:0]        lk_root,
    input logic                    fill_en,
    input logic                    rsp_valid,
    input logic [2:0]              rsp_level,
    input logic [PPN_W-1:0]        rsp_ppn,
    input logic [ENTRIES-1:0]      ent_vld,
    input logic [ENTRIES-1:0][1:0] ent_plen,
    input logic [ENTRIES-1:0]      lk_hit,
    input logic [PTR_W-1:0]        ptr_q,
    input logic [1:0]              alloc_cnt
);
    logic [2:0][ENTRIES-1:0] hit_by_len;
    logic [PTR_W:0]          ptr_sum;
    logic [PTR_W-1:0]        ptr_expect;

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                hit_by_len[k][e] = lk_hit[e] && (ent_plen[e] == 2'(k+1));
            end
        end
        ptr_sum = {1'b0, ptr_q} + (PTR_W+1)'(alloc_cnt);
        if (ptr_sum >= (PTR_W+1)'(ENTRIES)) ptr_sum = ptr_sum - (PTR_W+1)'(ENTRIES);
        ptr_expect = ptr_sum[PTR_W-1:0];
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    assert_miss_root_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_level == 3'd4) |-> rsp_ppn == $past(lk_root));

    assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_level >= 3'd1 && rsp_level <= 3'd4));

    for (genvar k = 0; k < 3; k++) begin : g_uniq
        assert_unique_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit_by_len[k]));
    end

    assert_ptr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all) |=> ptr_q == $past(ptr_expect));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (ent_vld == '0 && ptr_q == '0));

endmodule

bind utc_top utc_top_chk #(.IDX_W(IDX_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_all (flush_all),
    .lk_req    (lk_req),
    .lk_root   (lk_root),
    .fill_en   (fill_en),
    .rsp_valid (rsp_valid),
    .rsp_level (rsp_level),
    .rsp_ppn   (rsp_ppn),
    .ent_vld   (ent_vld),
    .ent_plen  (ent_plen),
    .lk_hit    (lk_hit),
    .ptr_q     (ptr_q),
    .alloc_cnt (alloc_cnt)
);

// File: tb/utc_top_test.sv
module utc_top_test;
    localparam int IW = 9;
    localparam int PW = 12;
    localparam int E  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_all = 1'b0;
    logic lk_req = 1'b0;
    logic [4*IW-1:0] lk_vidx = '0;
    logic [PW-1:0]   lk_root = '0;
    logic fill_en = 1'b0;
    logic [3*IW-1:0] fill_key = '0;
    logic [PW-1:0]   fb3 = '0, fb2 = '0, fb1 = '0;
    logic            rsp_valid;
    logic [2:0]      rsp_level;
    logic [PW-1:0]   rsp_ppn;

    utc_top #(.IDX_W(IW), .PPN_W(PW), .ENTRIES(E)) uut (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .lk_req(lk_req), .lk_vidx(lk_vidx), .lk_root(lk_root),
        .fill_en(fill_en), .fill_key(fill_key),
        .fill_base_l3(fb3), .fill_base_l2(fb2), .fill_base_l1(fb1),
        .rsp_valid(rsp_valid), .rsp_level(rsp_level), .rsp_ppn(rsp_ppn)
    );

    always #2.5ns clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model
    bit              m_vld [E];
    int              m_len [E];
    logic [3*IW-1:0] m_tag [E];
    logic [PW-1:0]   m_ppn [E];
    int              m_ptr;

    task automatic chk(string req, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic bit pmatch(logic [3*IW-1:0] t, logic [3*IW-1:0] k, int len);
        for (int f = 0; f < len; f++)
            if (t[(3-f)*IW-1 -: IW] != k[(3-f)*IW-1 -: IW]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void m_look(logic [3*IW-1:0] k, logic [PW-1:0] root,
                                   output int lvl, output logic [PW-1:0] p);
        int best = 0;
        p = root;
        for (int e = 0; e < E; e++)
            if (m_vld[e] && m_len[e] > best && pmatch(m_tag[e], k, m_len[e])) begin
                best = m_len[e];
                p = m_ppn[e];
            end
        lvl = 4 - best;
    endfunction

    function automatic void m_update();
        bit need [3];
        logic [PW-1:0] b [3];
        if (flush_all) begin
            for (int e = 0; e < E; e++) m_vld[e] = 1'b0;
            m_ptr = 0;
        end else if (fill_en) begin
            b[0] = fb3; b[1] = fb2; b[2] = fb1;
            for (int k = 0; k < 3; k++) begin
                need[k] = 1'b1;
                for (int e = 0; e < E; e++)
                    if (m_vld[e] && m_len[e] == k+1 && pmatch(m_tag[e], fill_key, k+1))
                        need[k] = 1'b0;
            end
            for (int k = 0; k < 3; k++)
                if (need[k]) begin
                    m_vld[m_ptr] = 1'b1;
                    m_len[m_ptr] = k+1;
                    m_tag[m_ptr] = fill_key;
                    m_ppn[m_ptr] = b[k];
                    m_ptr = (m_ptr + 1) % E;
                end
        end
    endfunction

    // one cycle: expectation from pre-edge model, then compare after the edge
    task automatic cyc(string req);
        bit req_s = lk_req;
        int el;
        logic [PW-1:0] ep;
        m_look(lk_vidx[4*IW-1:IW], lk_root, el, ep);
        @(posedge clk);
        m_update();
        @(negedge clk);
        chk(req, longint'(rsp_valid), longint'(req_s));
        if (req_s) begin
            chk(req, longint'(rsp_level), longint'(el));
            chk(req, longint'(rsp_ppn), longint'(ep));
        end
        lk_req = 1'b0; fill_en = 1'b0; flush_all = 1'b0;
    endtask

    task automatic look(logic [IW-1:0] a, logic [IW-1:0] b, logic [IW-1:0] c, logic [IW-1:0] d);
        lk_req = 1'b1; lk_vidx = {a, b, c, d}; lk_root = 12'h7e1;
    endtask

    task automatic fill(logic [IW-1:0] a, logic [IW-1:0] b, logic [IW-1:0] c,
                        logic [PW-1:0] p3, logic [PW-1:0] p2, logic [PW-1:0] p1);
        fill_en = 1'b1; fill_key = {a, b, c}; fb3 = p3; fb2 = p2; fb1 = p1;
    endtask

    // direct comparison of a lookup result against a hand value
    task automatic look_exp(string req, logic [IW-1:0] a, logic [IW-1:0] b, logic [IW-1:0] c,
                            int lvl, logic [PW-1:0] p);
        look(a, b, c, 9'h0c3);
        @(posedge clk);
        m_update();
        @(negedge clk);
        chk(req, longint'(rsp_valid), 1);
        chk(req, longint'(rsp_level), longint'(lvl));
        chk(req, longint'(rsp_ppn), longint'(p));
        lk_req = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < E; e++) begin
            m_vld[e] = 1'b0; m_len[e] = 0; m_tag[e] = '0; m_ppn[e] = '0;
        end
        m_ptr = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", longint'(rsp_valid), 0);
        chk("R1", longint'(rsp_level), 4);
        chk("R1", longint'(rsp_ppn), 0);
        rst_n = 1'b1;
        @(negedge clk);
        look_exp("R1", 9'h0b9, 9'h00c, 9'h0ae, 12'h7e1 == 12'h7e1 ? 4 : 0, 12'h7e1);

        // R2: idle cycle gives no response
        cyc("R2");

        // R6: fill a completed walk
        fill(9'h0b9, 9'h00c, 9'h0ae, 12'h042, 12'h125, 12'h508);
        cyc("R6");
        look_exp("R6", 9'h0b9, 9'h00c, 9'h0ae, 1, 12'h508);
        // R4: two-index match resumes at level 2
        look_exp("R4", 9'h0b9, 9'h00c, 9'h0dd, 2, 12'h125);
        look_exp("R4", 9'h0b9, 9'h1ff, 9'h0ae, 3, 12'h042);
        // R3: miss
        look_exp("R3", 9'h0b8, 9'h00c, 9'h0ae, 4, 12'h7e1);
        // R5: all three lengths match, longest wins
        look_exp("R5", 9'h0b9, 9'h00c, 9'h0ae, 1, 12'h508);

        // R7: refill of a held key keeps old bases, consumes no slot
        fill(9'h0b9, 9'h00c, 9'h0ae, 12'h111, 12'h222, 12'h333);
        cyc("R7");
        look_exp("R7", 9'h0b9, 9'h00c, 9'h0ae, 1, 12'h508);
        look_exp("R7", 9'h0b9, 9'h00c, 9'h001, 2, 12'h125);

        // R10: lookup with same-cycle fill sees old contents
        look(9'h0b9, 9'h00c, 9'h0b0, 9'h000);
        fill(9'h0b9, 9'h00c, 9'h0b0, 12'h444, 12'h555, 12'h666);
        @(posedge clk); m_update(); @(negedge clk);
        chk("R10", longint'(rsp_level), 2);
        chk("R10", longint'(rsp_ppn), 12'h125);
        lk_req = 1'b0; fill_en = 1'b0;
        look_exp("R10", 9'h0b9, 9'h00c, 9'h0b0, 1, 12'h666);

        // R9: flush with same-cycle fill; lookup in the flush cycle sees old contents
        look(9'h0b9, 9'h00c, 9'h0ae, 9'h000);
        flush_all = 1'b1;
        fill(9'h0aa, 9'h0bb, 9'h0cc, 12'h001, 12'h002, 12'h003);
        @(posedge clk); m_update(); @(negedge clk);
        chk("R10", longint'(rsp_level), 1);
        flush_all = 1'b0; fill_en = 1'b0; lk_req = 1'b0;
        look_exp("R9", 9'h0b9, 9'h00c, 9'h0ae, 4, 12'h7e1);
        look_exp("R9", 9'h0aa, 9'h0bb, 9'h0cc, 4, 12'h7e1);

        // R8: three fresh keys overflow 8 slots; key 1's 1-index prefix is replaced
        fill(9'h001, 9'h011, 9'h021, 12'h101, 12'h102, 12'h103); cyc("R8");
        fill(9'h001, 9'h011, 9'h021, 12'h901, 12'h902, 12'h903); cyc("R7");
        fill(9'h002, 9'h012, 9'h022, 12'h201, 12'h202, 12'h203); cyc("R8");
        look_exp("R8", 9'h001, 9'h1f0, 9'h000, 3, 12'h101);
        fill(9'h003, 9'h013, 9'h023, 12'h301, 12'h302, 12'h303); cyc("R8");
        look_exp("R8", 9'h001, 9'h1f0, 9'h000, 4, 12'h7e1);
        look_exp("R8", 9'h001, 9'h011, 9'h021, 1, 12'h103);
        look_exp("R8", 9'h003, 9'h013, 9'h1f0, 2, 12'h302);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            lk_req    = ($urandom % 10) < 7;
            lk_vidx   = {9'($urandom % 4), 9'($urandom % 4), 9'($urandom % 4), 9'($urandom)};
            lk_root   = 12'($urandom);
            fill_en   = ($urandom % 10) < 3;
            fill_key  = {9'($urandom % 4), 9'($urandom % 4), 9'($urandom % 4)};
            fb3 = 12'($urandom); fb2 = 12'($urandom); fb1 = 12'($urandom);
            flush_all = ($urandom % 100) < 2;
            cyc("R5");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule